// File: doc/BRIEF.md
# Hot-Swap Bus Connection Controller

This block decides when the two-wire serial bus segment on a plug-in card is joined to a bus that is already running on the backplane. It starts disconnected and ignores the bus until a supply-good input is high. Then it waits for the backplane-side transfer in progress to finish, shown by a STOP condition or an idle bus. It also waits until both card-side lines are high. Only then does it raise the connection enable and a READY flag.

While connected, the block joins the two sides so they act as one wired-AND bus. Each open-drain line appears as a sampled level input and a pull-low output. A low seen on one side makes the block pull the matching line on the other side low. A side is never pulled because of its own level. A separate stuck-bus recovery block can break the link through a single disconnect-request input. The link then drops at once, and reconnecting repeats the whole qualification.

Top module: `hotswap_link_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released until qualification completes, `link_en`, `ready` and all four pull outputs are 0.
- R2: While `supply_ok` is 0 the block stays disconnected. A STOP pattern that occurs while `supply_ok` is 0 does not count toward qualification.
- R3: Once `supply_ok` is 1, a STOP completes the input-side part of qualification. A STOP is a 0-to-1 change of `bp_sda_i` while `bp_scl_i` is 1.
- R4: Once `supply_ok` is 1, the input-side part of qualification also completes when `bp_sda_i` and `bp_scl_i` have both been 1 for `IDLE_CYC` consecutive cycles. A held low on `bp_sda_i` with `bp_scl_i` high never completes it.
- R5: After the input side has qualified, the link is not made until `cd_sda_i` and `cd_scl_i` are both 1.
- R6: `link_en` and `ready` always rise and fall in the same cycle.
- R7: While linked, each pull output follows the opposite side's level of the same line, inverted. `cd_sda_pull` is the inverse of `bp_sda_i`, `bp_sda_pull` is the inverse of `cd_sda_i`, and SCL works the same way. A pull output depends only on the opposite side's level, after two synchronizer stages.
- R8: While not linked, all four pull outputs are 0 whatever the line levels.
- R9: `link_en` and `ready` go to 0 in the same cycle that `disc_req` rises or `supply_ok` falls, with no clock edge needed.
- R10: After a disconnect, reconnection needs a fresh STOP or idle period followed by both card-side lines high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_ok | input | 1 | Supply above lockout threshold |
| disc_req | input | 1 | Disconnect request from the stuck-bus recovery block |
| bp_sda_i | input | 1 | Sampled level of backplane-side SDA |
| bp_scl_i | input | 1 | Sampled level of backplane-side SCL |
| cd_sda_i | input | 1 | Sampled level of card-side SDA |
| cd_scl_i | input | 1 | Sampled level of card-side SCL |
| bp_sda_pull | output | 1 | Pull backplane-side SDA low |
| bp_scl_pull | output | 1 | Pull backplane-side SCL low |
| cd_sda_pull | output | 1 | Pull card-side SDA low |
| cd_scl_pull | output | 1 | Pull card-side SCL low |
| link_en | output | 1 | Connection enable |
| ready | output | 1 | Link established flag |

## Verification
The hardest case to reach is showing that a STOP alone connects the card, and not an idle period that begins right after it. The stimulus holds backplane SDA low with SCL high for longer than the idle window, so neither qualifier can fire. It then releases SDA and samples READY well before `IDLE_CYC` cycles of idle could have passed. A STOP made while supply is low and followed by a new held low shows that events before power-good are discarded. Holding one card-side line low after the input side qualifies isolates the card-side condition.

// File: rtl/hsl_pkg.sv
package hsl_pkg;
  typedef enum logic [1:0] {
    ST_OFF      = 2'd0,
    ST_WAIT_END = 2'd1,
    ST_WAIT_OUT = 2'd2,
    ST_LINKED   = 2'd3
  } link_st_e;
endpackage

// File: rtl/hsl_rst_sync.sv
module hsl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/hsl_sync.sv
module hsl_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    // lines idle high, so the chain resets to 1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= {sh_q[STAGES-2:0], d[b]};
    end
    assign q[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/hsl_qual.sv
module hsl_qual #(
  parameter int IDLE_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic sda,
  input  logic scl,
  output logic end_hit
);
  localparam int CW = (IDLE_CYC > 2) ? $clog2(IDLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYC - 1);

  logic          sda_prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          both_hi, stop_hit, idle_hit;

  assign both_hi  = sda & scl;
  assign stop_hit = arm & scl & sda & ~sda_prev_q;
  assign idle_hit = arm & both_hi & (cnt_q == LAST);
  assign end_hit  = stop_hit | idle_hit;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!(arm && both_hi)) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != LAST) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev_q <= 1'b1;
      cnt_q      <= '0;
    end else begin
      sda_prev_q <= sda;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R4
  idle_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $past(arm && both_hi));
endmodule

// File: rtl/hsl_fsm.sv
module hsl_fsm
  import hsl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic disc_req,
  input  logic end_hit,
  input  logic out_hi,
  output logic arm,
  output logic linked
);
  link_st_e st_q, st_d;
  logic     go;

  assign go = supply_ok & ~disc_req;

  always_comb begin
    st_d = st_q;
    if (!go) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:      st_d = ST_WAIT_END;
        ST_WAIT_END: if (end_hit) st_d = ST_WAIT_OUT;
        ST_WAIT_OUT: if (out_hi)  st_d = ST_LINKED;
        ST_LINKED:   st_d = ST_LINKED;
        default:     st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign arm    = (st_q == ST_WAIT_END);
  assign linked = (st_q == ST_LINKED);

  // R5
  link_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LINKED && $past(st_q) != ST_LINKED) |->
      $past(st_q == ST_WAIT_OUT && out_hi));

  // R10
  wait_out_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT_OUT && $past(st_q) != ST_WAIT_OUT) |->
      $past(st_q == ST_WAIT_END && end_hit));
endmodule

// File: rtl/hsl_wand.sv
module hsl_wand (
  input  logic en,
  input  logic bp_sda,
  input  logic bp_scl,
  input  logic cd_sda,
  input  logic cd_scl,
  output logic bp_sda_pull,
  output logic bp_scl_pull,
  output logic cd_sda_pull,
  output logic cd_scl_pull
);
  // each side is driven only by what the opposite side shows
  assign cd_sda_pull = en & ~bp_sda;
  assign cd_scl_pull = en & ~bp_scl;
  assign bp_sda_pull = en & ~cd_sda;
  assign bp_scl_pull = en & ~cd_scl;
endmodule

// File: rtl/hotswap_link_ctrl.sv
module hotswap_link_ctrl #(
  parameter int CLK_MHZ  = 200,
  parameter int IDLE_US  = 50,
  parameter int IDLE_CYC = CLK_MHZ * IDLE_US,
  parameter int SYNC_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic disc_req,
  input  logic bp_sda_i,
  input  logic bp_scl_i,
  input  logic cd_sda_i,
  input  logic cd_scl_i,
  output logic bp_sda_pull,
  output logic bp_scl_pull,
  output logic cd_sda_pull,
  output logic cd_scl_pull,
  output logic link_en,
  output logic ready
);
  localparam int NLINE = 4;

  logic             rst_n_s;
  logic [NLINE-1:0] raw, syn;
  logic             arm, linked, end_hit, out_hi;

  hsl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  assign raw = {bp_sda_i, bp_scl_i, cd_sda_i, cd_scl_i};

  hsl_sync #(.W(NLINE), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d(raw), .q(syn)
  );

  hsl_qual #(.IDLE_CYC(IDLE_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n_s), .arm(arm),
    .sda(syn[3]), .scl(syn[2]), .end_hit(end_hit)
  );

  assign out_hi = syn[1] & syn[0];

  hsl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_s), .supply_ok(supply_ok), .disc_req(disc_req),
    .end_hit(end_hit), .out_hi(out_hi), .arm(arm), .linked(linked)
  );

  // immediate drop on disconnect request or supply loss
  assign link_en = linked & supply_ok & ~disc_req;
  assign ready   = link_en;

  hsl_wand u_wand (
    .en(link_en),
    .bp_sda(syn[3]), .bp_scl(syn[2]), .cd_sda(syn[1]), .cd_scl(syn[0]),
    .bp_sda_pull(bp_sda_pull), .bp_scl_pull(bp_scl_pull),
    .cd_sda_pull(cd_sda_pull), .cd_scl_pull(cd_scl_pull)
  );

  // R8
  idle_pulls_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !link_en |-> !(bp_sda_pull | bp_scl_pull | cd_sda_pull | cd_scl_pull));

  // R9
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (disc_req || !supply_ok) |-> !ready);

  // R6
  rise_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(ready) |-> $past(linked == 1'b0) || !$past(supply_ok) || $past(disc_req));
endmodule

// File: tb/sim_hotswap_link_ctrl.sv
module sim_hotswap_link_ctrl;
  localparam int IDLE = 20;

  logic clk, rst_n, supply_ok, disc_req;
  logic bp_sda_i, bp_scl_i, cd_sda_i, cd_scl_i;
  logic bp_sda_pull, bp_scl_pull, cd_sda_pull, cd_scl_pull, link_en, ready;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // stimulus {bp_sda,bp_scl,cd_sda,cd_scl}, expected {bp_sda_pull,bp_scl_pull,cd_sda_pull,cd_scl_pull}
  localparam logic [7:0] VEC [16] = '{
    8'h0F, 8'h1B, 8'h27, 8'h33, 8'h4E, 8'h5A, 8'h66, 8'h72,
    8'h8D, 8'h99, 8'hA5, 8'hB1, 8'hCC, 8'hD8, 8'hE4, 8'hF0
  };

  hotswap_link_ctrl #(.IDLE_CYC(IDLE)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .disc_req(disc_req),
    .bp_sda_i(bp_sda_i), .bp_scl_i(bp_scl_i), .cd_sda_i(cd_sda_i), .cd_scl_i(cd_scl_i),
    .bp_sda_pull(bp_sda_pull), .bp_scl_pull(bp_scl_pull),
    .cd_sda_pull(cd_sda_pull), .cd_scl_pull(cd_scl_pull),
    .link_en(link_en), .ready(ready)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] pulls();
    return {bp_sda_pull, bp_scl_pull, cd_sda_pull, cd_scl_pull};
  endfunction

  task automatic lines(input logic [3:0] v);
    {bp_sda_i, bp_scl_i, cd_sda_i, cd_scl_i} = v;
  endtask

  initial begin
    rst_n = 0; supply_ok = 0; disc_req = 0;
    lines(4'hF);
    cyc(3);
    chk({link_en, ready, 2'b0, pulls()}, 8'h00, "R1 outputs low in reset");
    rst_n = 1;
    cyc(10);
    chk({link_en, ready, 2'b0, pulls()}, 8'h00, "R1 outputs low after reset, no supply");

    // R2: STOP while supply low, then a held low before supply
    lines(4'b0111); cyc(4);
    lines(4'b1111); cyc(4);
    lines(4'b0111); cyc(4);
    supply_ok = 1;
    cyc(3 * IDLE);
    chk({7'b0, ready}, 8'h00, "R2 STOP before supply ignored");
    chk({7'b0, ready}, 8'h00, "R4 held SDA low blocks idle");
    // R3: STOP connects well before idle window could
    lines(4'b1111);
    cyc(8);
    chk({7'b0, ready}, 8'h01, "R3 STOP qualifies");
    chk({6'b0, link_en, ready}, 8'h03, "R6 enable and ready together");

    // R7 table walk while linked
    foreach (VEC[k]) begin
      lines(VEC[k][7:4]);
      cyc(3);
      chk({4'b0, pulls()}, {4'b0, VEC[k][3:0]}, $sformatf("R7 vector %0d", k));
    end
    lines(4'hF); cyc(3);
    chk({6'b0, link_en, ready}, 8'h03, "R7 link kept through traffic");

    // R9: disconnect request drops at once
    disc_req = 1;
    #1;
    chk({6'b0, link_en, ready}, 8'h00, "R9 disc_req immediate drop");
    lines(4'b0000);
    cyc(4);
    chk({4'b0, pulls()}, 8'h00, "R8 no pulls while disconnected");
    lines(4'hF);
    cyc(2);
    disc_req = 0;
    // R10 + R4: requalify through idle
    cyc(5);
    chk({7'b0, ready}, 8'h00, "R10 no instant reconnect");
    cyc(2 * IDLE);
    chk({6'b0, link_en, ready}, 8'h03, "R4 idle qualifies reconnect");

    // R9 supply drop
    supply_ok = 0;
    #1;
    chk({6'b0, link_en, ready}, 8'h00, "R9 supply loss immediate drop");
    cyc(3);
    // R5: card SCL held low after input qualifies
    lines(4'b1110);
    cyc(3);
    supply_ok = 1;
    cyc(3 * IDLE);
    chk({7'b0, ready}, 8'h00, "R5 waits for card lines high");
    chk({4'b0, pulls()}, 8'h00, "R8 no pulls while waiting");
    lines(4'b1111);
    cyc(6);
    chk({6'b0, link_en, ready}, 8'h03, "R5 connects once card lines high");

    // R1 reset mid-link
    rst_n = 0;
    #1;
    cyc(1);
    chk({6'b0, link_en, ready}, 8'h00, "R1 reset drops link");
    rst_n = 1;
    cyc(4);
    chk({6'b0, link_en, ready}, 8'h00, "R1 no link right after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule